// File: doc/BRIEF.md
# Memory-Operand Effective Address Generator

This block turns a memory-operand instruction into the byte address that a load or store will use. It takes a first instruction word, decodes its mode field and reads up to two registers (a base and an index) through a pair of combinational register-read ports. It then adds the fields that the mode selects: a 12-bit offset, the base value, an index scaled by a power of two, a 32-bit displacement, or the instruction pointer plus a fixed bias of 8. The address leaves on a one-cycle strobe, registered one clock after the last word of the instruction is accepted.

There are two encoding families. A short family carries the offset in the first word and always needs one word. A long family has a 4-bit mode. Some long modes need a second word that carries the displacement. For those, the block parks in a waiting state and drops its ready-for-first-word output until the next word arrives. Reserved mode encodings, and out-of-range scale values, produce a one-cycle fault pulse and no address.

The state machine has two states. ST_IDLE accepts a first word. Its transitions are IDLE→IDLE, taken for one-word modes and for faulting words, and IDLE→WAIT_DISP, taken when a legal two-word mode is accepted. ST_WAIT_DISP takes the displacement word and makes one transition, WAIT_DISP→IDLE, when that word arrives.

Top module: `ea_gen`

## Requirements
- R1: While reset is high, and in the cycle after it falls, `first_ready` is 1 and both `ea_valid` and `ea_fault` are 0.
- R2: First-word layout: bits [18:14] select the base register. Bit 12 = 0 marks the short family, with its 2-bit mode in bits [13:12] and an unsigned offset in bits [11:0]. Short mode 00 gives address = offset zero-extended, and the base value has no effect.
- R3: Short mode 10 gives address = base value + offset.
- R4: A long-family word has bit 12 = 1. Its mode sits in bits [13:10], its scale in bits [9:7] and its index register number in bits [4:0]. Long mode 0100 gives the base value. Long mode 0111 gives base + (index << scale). Both are one-word modes.
- R5: Long mode 0101 gives IP + displacement + 8. The IP is the value of `ip_addr` when the first word is accepted, and the displacement is the entire second word.
- R6: Long mode 1100 gives the displacement. Mode 1101 gives base + displacement. Mode 1110 gives (index << scale) + displacement. Mode 1111 gives base + (index << scale) + displacement. Register values are read in the cycle the displacement word is accepted.
- R7: After a legal two-word first word is accepted, `first_ready` is 0 until the next accepted word, which is taken as the displacement. `first_ready` then returns to 1.
- R8: `ea_valid` is high for exactly one cycle per legal instruction, in the cycle after its final word is accepted, and never together with `ea_fault`.
- R9: Long mode 0110 is reserved. It raises `ea_fault` for one cycle in the cycle after acceptance, produces no `ea_valid`, and leaves the block ready for a new first word.
- R10: In modes 0111, 1110 and 1111, a scale above 4 raises `ea_fault` in the same way as R9. No second word is awaited.
- R11: All address sums are taken modulo 2^32, and a wrap raises no fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| word_valid | input | 1 | An instruction word is presented this cycle |
| word_data | input | 32 | First word or displacement word |
| first_ready | output | 1 | High when the next word is taken as a first word |
| ip_addr | input | 32 | Address of the current instruction |
| base_sel | output | 5 | Base register read number |
| base_val | input | 32 | Base register read data (same cycle) |
| index_sel | output | 5 | Index register read number |
| index_val | input | 32 | Index register read data (same cycle) |
| ea_valid | output | 1 | One-cycle strobe: `ea_addr` is valid |
| ea_addr | output | 32 | Computed effective address |
| ea_fault | output | 1 | One-cycle invalid-opcode pulse |

## Verification
The bench aims at the words whose meaning depends on state. A displacement word whose own bits look like a reserved or short-mode first word must still be taken as a displacement. A design that decoded it afresh would fault or emit a stray address. Scale 4 against scale 5 is probed in all three indexed modes: an off-by-one limit either faults on a legal shift or wraps the shift silently. IP-relative words are given an `ip_addr` that changes between the two words, which exposes a design that samples the IP late or drops the +8. A base near 2^32 with a large displacement checks for a wrap with no fault. Back-to-back one-word instructions check that the strobe stays one cycle per instruction and does not stretch.

// File: rtl/eagen_pkg.sv
package eagen_pkg;
    localparam int ADDR_W    = 32;
    localparam int SEL_W     = 5;
    localparam int OFS_W     = 12;
    localparam int SCALE_W   = 3;
    localparam int MODE_W    = 4;
    localparam int MAX_SHIFT = 4;
    localparam int IP_BIAS   = 8;

    // field positions within the first word
    localparam int OFS_LSB   = 0;
    localparam int IDX_LSB   = 0;
    localparam int SCALE_LSB = 7;
    localparam int MODE_LSB  = 10;
    localparam int BASE_LSB  = 14;

    // long-family mode codes
    localparam logic [MODE_W-1:0] M_BASE      = 4'b0100;
    localparam logic [MODE_W-1:0] M_IPREL     = 4'b0101;
    localparam logic [MODE_W-1:0] M_RSVD      = 4'b0110;
    localparam logic [MODE_W-1:0] M_BASE_IDX  = 4'b0111;
    localparam logic [MODE_W-1:0] M_DISP      = 4'b1100;
    localparam logic [MODE_W-1:0] M_BASE_DISP = 4'b1101;
    localparam logic [MODE_W-1:0] M_IDX_DISP  = 4'b1110;
    localparam logic [MODE_W-1:0] M_FULL      = 4'b1111;

    typedef enum logic {
        ST_IDLE,
        ST_WAIT_DISP
    } ag_state_t;

    typedef struct packed {
        logic               add_ofs;
        logic               use_base;
        logic               use_index;
        logic               use_disp;
        logic               use_ip;
        logic               reserved;
        logic               bad_scale;
        logic [SEL_W-1:0]   base_sel;
        logic [SEL_W-1:0]   index_sel;
        logic [SCALE_W-1:0] scale;
        logic [OFS_W-1:0]   offset;
    } ag_dec_t;
endpackage

// File: rtl/eagen_decode.sv
module eagen_decode
    import eagen_pkg::*;
(
    input  logic [ADDR_W-1:0] word_i,
    output ag_dec_t           dec_o
);
    logic [MODE_W-1:0] mode;
    assign mode = word_i[MODE_LSB +: MODE_W];

    always_comb begin
        dec_o           = '0;
        dec_o.base_sel  = word_i[BASE_LSB +: SEL_W];
        dec_o.index_sel = word_i[IDX_LSB +: SEL_W];
        dec_o.scale     = word_i[SCALE_LSB +: SCALE_W];
        dec_o.offset    = word_i[OFS_LSB +: OFS_W];
        if (!mode[2]) begin
            // short family: upper mode bit picks base+offset
            dec_o.add_ofs  = 1'b1;
            dec_o.use_base = mode[3];
        end else begin
            case (mode)
                M_BASE:      dec_o.use_base = 1'b1;
                M_IPREL: begin
                    dec_o.use_ip   = 1'b1;
                    dec_o.use_disp = 1'b1;
                end
                M_BASE_IDX: begin
                    dec_o.use_base  = 1'b1;
                    dec_o.use_index = 1'b1;
                end
                M_DISP:      dec_o.use_disp = 1'b1;
                M_BASE_DISP: begin
                    dec_o.use_base = 1'b1;
                    dec_o.use_disp = 1'b1;
                end
                M_IDX_DISP: begin
                    dec_o.use_index = 1'b1;
                    dec_o.use_disp  = 1'b1;
                end
                M_FULL: begin
                    dec_o.use_base  = 1'b1;
                    dec_o.use_index = 1'b1;
                    dec_o.use_disp  = 1'b1;
                end
                default:     dec_o.reserved = 1'b1;
            endcase
        end
        dec_o.bad_scale = dec_o.use_index &&
                          (int'(dec_o.scale) > MAX_SHIFT);
    end
endmodule

// File: rtl/eagen_sum.sv
module eagen_sum
    import eagen_pkg::*;
(
    input  ag_dec_t           dec_i,
    input  logic [ADDR_W-1:0] base_i,
    input  logic [ADDR_W-1:0] index_i,
    input  logic [ADDR_W-1:0] disp_i,
    input  logic [ADDR_W-1:0] ip_i,
    output logic [ADDR_W-1:0] ea_o
);
    localparam logic [ADDR_W-1:0] BIAS = ADDR_W'(IP_BIAS);

    logic [ADDR_W-1:0] t_base, t_idx, t_disp, t_ofs, t_ip;

    always_comb begin
        t_base = dec_i.use_base  ? base_i : '0;
        t_idx  = dec_i.use_index ? (index_i << dec_i.scale) : '0;
        t_disp = dec_i.use_disp  ? disp_i : '0;
        t_ofs  = dec_i.add_ofs   ? ADDR_W'(dec_i.offset) : '0;
        t_ip   = dec_i.use_ip    ? (ip_i + BIAS) : '0;
        ea_o   = t_base + t_idx + t_disp + t_ofs + t_ip;
    end
endmodule

// File: rtl/ea_gen.sv
module ea_gen
    import eagen_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              word_valid,
    input  logic [ADDR_W-1:0] word_data,
    output logic              first_ready,
    input  logic [ADDR_W-1:0] ip_addr,
    output logic [SEL_W-1:0]  base_sel,
    input  logic [ADDR_W-1:0] base_val,
    output logic [SEL_W-1:0]  index_sel,
    input  logic [ADDR_W-1:0] index_val,
    output logic              ea_valid,
    output logic [ADDR_W-1:0] ea_addr,
    output logic              ea_fault
);
    ag_state_t         state_q, state_d;
    ag_dec_t           dec_live, dec_q, dec_cur;
    logic [ADDR_W-1:0] ip_q, ip_cur, sum;
    logic              live_bad, live_two;

    eagen_decode u_dec (
        .word_i (word_data),
        .dec_o  (dec_live)
    );

    assign dec_cur   = (state_q == ST_IDLE) ? dec_live : dec_q;
    assign ip_cur    = (state_q == ST_IDLE) ? ip_addr  : ip_q;
    assign base_sel  = dec_cur.base_sel;
    assign index_sel = dec_cur.index_sel;

    eagen_sum u_sum (
        .dec_i   (dec_cur),
        .base_i  (base_val),
        .index_i (index_val),
        .disp_i  (word_data),
        .ip_i    (ip_cur),
        .ea_o    (sum)
    );

    assign live_bad    = dec_live.reserved || dec_live.bad_scale;
    assign live_two    = dec_live.use_disp;
    assign first_ready = (state_q == ST_IDLE);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      if (word_valid && !live_bad && live_two) state_d = ST_WAIT_DISP;
            ST_WAIT_DISP: if (word_valid) state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            dec_q   <= '0;
            ip_q    <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && word_valid) begin
                dec_q <= dec_live;
                ip_q  <= ip_addr;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ea_valid <= 1'b0;
            ea_fault <= 1'b0;
            ea_addr  <= '0;
        end else begin
            ea_valid <= 1'b0;
            ea_fault <= 1'b0;
            unique case (state_q)
                ST_IDLE: if (word_valid) begin
                    if (live_bad) begin
                        ea_fault <= 1'b1;
                    end else if (!live_two) begin
                        ea_valid <= 1'b1;
                        ea_addr  <= sum;
                    end
                end
                ST_WAIT_DISP: if (word_valid) begin
                    ea_valid <= 1'b1;
                    ea_addr  <= sum;
                end
            endcase
        end
    end
endmodule

// File: rtl/eagen_chk.sv
module eagen_chk (
    input logic        clk,
    input logic        rst,
    input logic        word_valid,
    input logic [31:0] word_data,
    input logic        first_ready,
    input logic        ea_valid,
    input logic [31:0] ea_addr,
    input logic        ea_fault
);
    p_reset_idle_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (first_ready && !ea_valid && !ea_fault));

    p_abs_short_r2: assert property (@(posedge clk) disable iff (rst)
        (word_valid && first_ready && word_data[13:12] == 2'b00)
        |=> (ea_valid && ea_addr == {20'd0, $past(word_data[11:0])}));

    p_wait_entry_r7: assert property (@(posedge clk) disable iff (rst)
        (word_valid && first_ready &&
         (word_data[13:10] == 4'b0101 || word_data[13:10] == 4'b1100 ||
          word_data[13:10] == 4'b1101))
        |=> !first_ready);

    p_wait_exit_r7: assert property (@(posedge clk) disable iff (rst)
        (word_valid && !first_ready) |=> (first_ready && ea_valid));

    p_excl_r8: assert property (@(posedge clk) disable iff (rst)
        !(ea_valid && ea_fault));

    p_reserved_r9: assert property (@(posedge clk) disable iff (rst)
        (word_valid && first_ready && word_data[13:10] == 4'b0110)
        |=> (ea_fault && !ea_valid && first_ready));

    p_scale_r10: assert property (@(posedge clk) disable iff (rst)
        (word_valid && first_ready && word_data[13:10] == 4'b0111 &&
         word_data[9:7] > 3'd4)
        |=> (ea_fault && !ea_valid));
endmodule

bind ea_gen eagen_chk u_chk (.*);

// File: tb/sim_ea_gen.sv
module sim_ea_gen;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        word_valid = 1'b0;
    logic [31:0] word_data = '0;
    logic [31:0] ip_addr = '0;
    logic        first_ready, ea_valid, ea_fault;
    logic [31:0] ea_addr, base_val, index_val;
    logic [4:0]  base_sel, index_sel;
    logic [31:0] regs [32];

    int checks = 0, errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    assign base_val  = regs[base_sel];
    assign index_val = regs[index_sel];

    ea_gen u0 (
        .clk(clk), .rst(rst), .word_valid(word_valid), .word_data(word_data),
        .first_ready(first_ready), .ip_addr(ip_addr), .base_sel(base_sel),
        .base_val(base_val), .index_sel(index_sel), .index_val(index_val),
        .ea_valid(ea_valid), .ea_addr(ea_addr), .ea_fault(ea_fault)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference model
    bit          m_wait = 1'b0;
    logic [31:0] m_first, m_ip;
    logic        e_valid = 1'b0, e_fault = 1'b0;
    logic [31:0] e_addr = '0;
    string       e_tag = "R1";

    always @(posedge clk) begin
        logic [31:0] w, b, x, d;
        logic [3:0]  md;
        int          sc;
        if (rst) begin
            m_wait = 0; e_valid = 0; e_fault = 0; e_tag = "R1";
        end else begin
            e_valid = 0; e_fault = 0;
            if (word_valid && !m_wait) begin
                w = word_data; md = w[13:10]; sc = int'(w[9:7]);
                b = regs[w[18:14]]; x = regs[w[4:0]];
                if (!w[12]) begin
                    e_valid = 1; e_addr = (w[13] ? b : 32'd0) + {20'd0, w[11:0]};
                    e_tag = w[13] ? "R3" : "R2";
                end else if (md == 4'b0110) begin
                    e_fault = 1; e_tag = "R9";
                end else if ((md == 4'b0111 || md == 4'b1110 || md == 4'b1111) && sc > 4) begin
                    e_fault = 1; e_tag = "R10";
                end else if (md == 4'b0100) begin
                    e_valid = 1; e_addr = b; e_tag = "R4";
                end else if (md == 4'b0111) begin
                    e_valid = 1; e_addr = b + (x << sc); e_tag = "R4";
                end else begin
                    m_wait = 1; m_first = w; m_ip = ip_addr; e_tag = "R7";
                end
            end else if (word_valid) begin
                d = word_data; md = m_first[13:10]; sc = int'(m_first[9:7]);
                b = regs[m_first[18:14]]; x = regs[m_first[4:0]];
                e_valid = 1; e_tag = (md == 4'b0101) ? "R5" : "R6";
                case (md)
                    4'b0101: e_addr = m_ip + d + 32'd8;
                    4'b1100: e_addr = d;
                    4'b1101: e_addr = b + d;
                    4'b1110: e_addr = (x << sc) + d;
                    default: e_addr = b + (x << sc) + d;
                endcase
                m_wait = 0;
            end
        end
    end

    always @(negedge clk) begin
        if (!done) begin
            chk({e_tag, "/R7 ready"}, {31'd0, first_ready}, {31'd0, !m_wait});
            chk({e_tag, "/R8 valid"}, {31'd0, ea_valid}, {31'd0, e_valid});
            chk({e_tag, "/R9 fault"}, {31'd0, ea_fault}, {31'd0, e_fault});
            if (e_valid) chk({e_tag, " addr"}, ea_addr, e_addr);
        end
    end

    function automatic logic [31:0] w_short(input logic m, input logic [4:0] b, input logic [11:0] o);
        return {13'd0, b, m, 1'b0, o};
    endfunction

    function automatic logic [31:0] w_long(input logic [3:0] m, input logic [4:0] b,
                                           input logic [4:0] x, input logic [2:0] s);
        return {13'd0, b, m, s, 2'b00, x};
    endfunction

    task automatic put(input logic [31:0] w);
        @(negedge clk);
        word_valid = 1'b1;
        word_data  = w;
        @(negedge clk);
        word_valid = 1'b0;
        word_data  = $urandom;
    endtask

    initial begin
        for (int i = 0; i < 32; i++) regs[i] = $urandom;
        regs[1] = 32'h1000_0000; regs[2] = 32'h0000_0010; regs[3] = 32'hFFFF_FFF0;
        repeat (3) @(negedge clk);
        // R1: during reset
        chk("R1 ready in reset", {31'd0, first_ready}, 32'd1);
        chk("R1 valid in reset", {31'd0, ea_valid}, 32'd0);
        chk("R1 fault in reset", {31'd0, ea_fault}, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 ready after reset", {31'd0, first_ready}, 32'd1);

        // R2: base value must not matter
        put(w_short(1'b0, 5'd3, 12'hFFF));
        chk("R2 abs offset", ea_addr, 32'h0000_0FFF);
        put(w_short(1'b1, 5'd1, 12'h123));
        chk("R3 base+offset", ea_addr, 32'h1000_0123);
        put(w_long(4'b0111, 5'd1, 5'd2, 3'd4));
        chk("R4 base+idx<<4", ea_addr, 32'h1000_0100);
        // R5: ip changes between words
        ip_addr = 32'h0000_4000;
        put(w_long(4'b0101, 5'd0, 5'd0, 3'd0));
        ip_addr = 32'h0000_9999;
        chk("R7 ready low waiting", {31'd0, first_ready}, 32'd0);
        // displacement that looks like a reserved first word
        put(w_long(4'b0110, 5'd0, 5'd0, 3'd0) | 32'h100);
        chk("R5 ip+disp+8", ea_addr, 32'h0000_4000 + 32'h1900 + 32'd8);
        // R11: wrap
        put(w_long(4'b1101, 5'd3, 5'd0, 3'd0));
        put(32'h0000_0020);
        chk("R11 wrap", ea_addr, 32'h0000_0010);
        // R10: scale 5 faults, scale 4 legal
        put(w_long(4'b1110, 5'd0, 5'd2, 3'd5));
        chk("R10 no wait after bad scale", {31'd0, first_ready}, 32'd1);
        put(w_long(4'b1111, 5'd1, 5'd2, 3'd4));
        put(32'h0000_0001);
        chk("R6 full", ea_addr, 32'h1000_0101);
        // R8: back-to-back one-word words
        @(negedge clk);
        word_valid = 1'b1;
        for (int i = 0; i < 6; i++) begin
            word_data = (i % 2 == 0) ? w_long(4'b0100, 5'(i), 5'd0, 3'd0)
                                     : w_short(1'b1, 5'(i), 12'(i * 7));
            @(negedge clk);
        end
        word_valid = 1'b0;
        @(negedge clk);
        // random mix
        for (int i = 0; i < 600; i++) begin
            logic [31:0] w;
            w = $urandom;
            if (i % 5 == 0) regs[$urandom % 32] = $urandom;
            ip_addr = $urandom;
            @(negedge clk);
            word_valid = ($urandom % 4) != 0;
            word_data  = w;
        end
        word_valid = 1'b0;
        repeat (3) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule